// File: doc/BRIEF.md
# Amount Entry and Balance Check

This block takes a transaction amount that a customer keys in one binary digit at a time and applies it to an account balance that has already been read. Each digit key shifts the amount one place left, and a Clear key empties it. When Enter is pressed, one shared adder-subtractor forms the candidate new balance. A deposit adds the amount to the balance. A withdrawal subtracts it, by adding the inverted amount with a carry-in of one. The carry or borrow out of that single adder decides whether the result fits in the balance width.

A result that does not fit raises an invalid flag and is never offered for write-back. A result that fits is held on the new-balance output, and the block waits in a verify step for the customer's answer. Key 1 confirms, and the block issues a one-cycle transaction-valid pulse that tells the surrounding logic to write the balance back. Key 0 backs out and issues a one-cycle cancel pulse. The memory access and the display are handled outside the block.

Top module: `amount_check_top`

## Requirements
- R1: After synchronous active-high reset, the new-balance output is 0 and the invalid flag, transaction-valid pulse and cancel pulse are all 0. The block starts in the amount-entry step with an empty amount.
- R2: A key strobe has no effect unless the deposit enable or the withdraw enable is high in the same cycle.
- R3: In the entry step, key code 4'h0 or 4'h1 shifts that bit into the low end of the W-bit amount, and the older bits move one place up. The first bit keyed ends up as the most significant bit after W keys, and bits shifted beyond W are lost.
- R4: In the entry step, key code 4'hC (Clear) sets the amount to zero.
- R5: Key code 4'hE (Enter) with the deposit enable high computes old balance plus amount. The result is viable only when the true sum is below 2^W.
- R6: Enter with only the withdraw enable high computes old balance minus amount. The result is viable only when the amount does not exceed the old balance, so an amount equal to the balance gives a viable zero.
- R7: When both enables are high at Enter, the operation is a deposit.
- R8: A viable result appears on the new-balance output one cycle after Enter. It clears the invalid flag and moves the block to the verify step.
- R9: An out-of-range result sets the invalid flag and leaves the new-balance output at its previous value. The block stays in the entry step with no pulse. The flag keeps its value until the next Enter.
- R10: Every Enter empties the amount, so the next entry starts from zero.
- R11: In the verify step, key 4'h1 gives a one-cycle transaction-valid pulse and key 4'h0 gives a one-cycle cancel pulse. Either key returns the block to the entry step.
- R12: In the verify step, all other key codes are ignored. The new-balance output stays stable from Enter until the confirm or cancel key, even if the old-balance input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dep_en | input | 1 | Deposit amount entry enable |
| wdr_en | input | 1 | Withdraw amount entry enable |
| key_stb | input | 1 | One-cycle key press strobe |
| key_code | input | KW (4) | Key code: 0, 1, C = Clear, E = Enter |
| bal_in | input | W (16) | Old balance read earlier |
| bal_out | output | W (16) | Candidate new balance, held for write-back |
| bad_txn | output | 1 | Out-of-range transaction flag |
| txn_ok | output | 1 | One-cycle confirm pulse (write-back allowed) |
| txn_cancel | output | 1 | One-cycle cancel pulse |

## Verification
The adder-subtractor is driven with seeded random balances and amounts in both directions. Random deposits split roughly evenly between carry and no carry, so they separate the viable path from the overflow path. Random withdrawals cover amounts on both sides of the balance and show whether the borrow is read with the correct polarity. Directed cases then probe the edges:
- a deposit one below and exactly at 2^W;
- a withdrawal equal to the balance and one more than it;
- seventeen digits keyed in, so the leading bit is lost;
- Clear in the middle of an entry;
- keys pressed with both enables low;
- both enables high at Enter.

In the verify step, each random transaction first gets an ignored key and a change of the balance input. This shows the held result is frozen. The transaction then ends with a confirm or cancel chosen at random, and the bench checks that the other pulse stays low.

// File: rtl/amt_pkg.sv
package amt_pkg;

    localparam int KEY_W = 4;

    localparam logic [KEY_W-1:0] KEY_ZERO  = 4'h0;
    localparam logic [KEY_W-1:0] KEY_ONE   = 4'h1;
    localparam logic [KEY_W-1:0] KEY_CLEAR = 4'hC;
    localparam logic [KEY_W-1:0] KEY_ENTER = 4'hE;

    typedef enum logic {
        ST_ENTRY  = 1'b0,
        ST_VERIFY = 1'b1
    } step_e;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } op_e;

    typedef struct packed {
        logic is_bit;
        logic is_clear;
        logic is_enter;
        logic bit_val;
    } key_dec_t;

    function automatic key_dec_t decode_key(input logic [KEY_W-1:0] k);
        key_dec_t d;
        d.is_bit   = (k == KEY_ZERO) || (k == KEY_ONE);
        d.is_clear = (k == KEY_CLEAR);
        d.is_enter = (k == KEY_ENTER);
        d.bit_val  = (k == KEY_ONE);
        return d;
    endfunction

    // deposit wins when both enables are high
    function automatic op_e pick_op(input logic dep, input logic wdr);
        return (!dep && wdr) ? OP_SUB : OP_ADD;
    endfunction

endpackage

// File: rtl/amt_shift.sv
module amt_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_in,
    input  logic         clr,
    output logic [W-1:0] amt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            amt <= '0;
        end else if (shift_en) begin
            amt <= {amt[W-2:0], bit_in};
        end
    end

    // R3: a shift moves the old low bits up by one place
    a_r3_shift_left: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !clr) |=> (amt[W-1:1] == $past(amt[W-2:0])));

    // R4: a clear empties the amount
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (amt == '0));
endmodule

// File: rtl/amt_addsub.sv
module amt_addsub
    import amt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] bal,
    input  logic [W-1:0] amt,
    input  op_e          op,
    output logic [W-1:0] sum,
    output logic         out_of_range
);
    localparam int SW = W + 1;

    logic          sub;
    logic [W-1:0]  operand;
    logic [SW-1:0] wide;

    always_comb begin
        sub          = (op == OP_SUB);
        operand      = sub ? ~amt : amt;
        wide         = {1'b0, bal} + {1'b0, operand} + {{(SW-1){1'b0}}, sub};
        sum          = wide[W-1:0];
        // carry flags overflow on add; a missing carry is a borrow on subtract
        out_of_range = sub ? ~wide[W] : wide[W];
    end
endmodule

// File: rtl/amt_ctrl.sv
module amt_ctrl
    import amt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rec,
    input  key_dec_t     kd,
    input  logic [W-1:0] sum,
    input  logic         out_of_range,
    output logic         in_entry,
    output logic [W-1:0] res,
    output logic         bad,
    output logic         ok_p,
    output logic         cancel_p
);
    step_e step;

    assign in_entry = (step == ST_ENTRY);

    always_ff @(posedge clk) begin
        if (rst) begin
            step     <= ST_ENTRY;
            res      <= '0;
            bad      <= 1'b0;
            ok_p     <= 1'b0;
            cancel_p <= 1'b0;
        end else begin
            ok_p     <= 1'b0;
            cancel_p <= 1'b0;
            if (rec) begin
                if (step == ST_ENTRY) begin
                    if (kd.is_enter) begin
                        bad <= out_of_range;
                        if (!out_of_range) begin
                            res  <= sum;
                            step <= ST_VERIFY;
                        end
                    end
                end else if (kd.is_bit) begin
                    ok_p     <= kd.bit_val;
                    cancel_p <= !kd.bit_val;
                    step     <= ST_ENTRY;
                end
            end
        end
    end

    // R11: a confirm or cancel pulse only follows a verify step
    a_r11_pulse_from_verify: assert property (@(posedge clk) disable iff (rst)
        (ok_p || cancel_p) |-> $past(step == ST_VERIFY));

    // R11: pulses last one cycle
    a_r11_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (ok_p || cancel_p) |=> !(ok_p || cancel_p));

    // R12: the held result does not move during verify
    a_r12_hold_result: assert property (@(posedge clk) disable iff (rst)
        (step == ST_VERIFY && $past(step == ST_VERIFY)) |-> $stable(res));

    // R9: an invalid result never reaches verify
    a_r9_bad_stays_entry: assert property (@(posedge clk) disable iff (rst)
        bad |-> (step == ST_ENTRY));
endmodule

// File: rtl/amount_check_top.sv
module amount_check_top
    import amt_pkg::*;
#(
    parameter int W  = 16,
    parameter int KW = KEY_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dep_en,
    input  logic          wdr_en,
    input  logic          key_stb,
    input  logic [KW-1:0] key_code,
    input  logic [W-1:0]  bal_in,
    output logic [W-1:0]  bal_out,
    output logic          bad_txn,
    output logic          txn_ok,
    output logic          txn_cancel
);
    logic         rec;
    key_dec_t     kd;
    op_e          op;
    logic         in_entry;
    logic [W-1:0] amt;
    logic [W-1:0] sum;
    logic         oor;

    assign rec = key_stb && (dep_en || wdr_en);
    assign kd  = decode_key(key_code);
    assign op  = pick_op(dep_en, wdr_en);

    amt_shift #(.W(W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (rec && in_entry && kd.is_bit),
        .bit_in   (kd.bit_val),
        .clr      (rec && in_entry && (kd.is_clear || kd.is_enter)),
        .amt      (amt)
    );

    amt_addsub #(.W(W)) u_addsub (
        .bal          (bal_in),
        .amt          (amt),
        .op           (op),
        .sum          (sum),
        .out_of_range (oor)
    );

    amt_ctrl #(.W(W)) u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .rec          (rec),
        .kd           (kd),
        .sum          (sum),
        .out_of_range (oor),
        .in_entry     (in_entry),
        .res          (bal_out),
        .bad          (bad_txn),
        .ok_p         (txn_ok),
        .cancel_p     (txn_cancel)
    );

    // R11: confirm and cancel never coincide
    a_r11_excl: assert property (@(posedge clk) disable iff (rst)
        !(txn_ok && txn_cancel));

    // R9: an invalid flag never comes with a confirm
    a_r9_no_ok_when_bad: assert property (@(posedge clk) disable iff (rst)
        bad_txn |-> !txn_ok);

    // R6: a viable withdrawal plus its amount gives back the old balance
    a_r6_wdr_relation: assert property (@(posedge clk) disable iff (rst)
        (rec && in_entry && kd.is_enter && op == OP_SUB && !oor)
            |-> ((sum + amt) == bal_in) && (amt <= bal_in));

    // R2: with both enables low, no key changes the amount
    a_r2_no_enable: assert property (@(posedge clk) disable iff (rst)
        !(dep_en || wdr_en) |=> $stable(amt));
endmodule

// File: tb/tb_amount_check_top.sv
module tb_amount_check_top;
    localparam int W       = 16;
    localparam int CLK_PER = 10;

    logic         clk = 1'b0;
    logic         rst;
    logic         dep_en, wdr_en, key_stb;
    logic [3:0]   key_code;
    logic [W-1:0] bal_in;
    logic [W-1:0] bal_out;
    logic         bad_txn, txn_ok, txn_cancel;

    int total = 0;
    int bad   = 0;
    logic [W-1:0] exp_out = '0;

    amount_check_top #(.W(W)) dut (
        .clk(clk), .rst(rst), .dep_en(dep_en), .wdr_en(wdr_en),
        .key_stb(key_stb), .key_code(key_code), .bal_in(bal_in),
        .bal_out(bal_out), .bad_txn(bad_txn), .txn_ok(txn_ok),
        .txn_cancel(txn_cancel)
    );

    always #(CLK_PER/2) clk = ~clk;

    task automatic chk(input logic cond, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic press(input logic [3:0] k);
        @(negedge clk);
        key_stb  = 1'b1;
        key_code = k;
        @(negedge clk);
        key_stb  = 1'b0;
    endtask

    task automatic key_bits(input logic [W-1:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) press({3'b000, v[i]});
    endtask

    function automatic logic model_bad(input logic dep, input logic [W-1:0] b,
                                       input logic [W-1:0] a);
        logic [W:0] s;
        s = {1'b0, b} + {1'b0, a};
        return dep ? s[W] : (a > b);
    endfunction

    function automatic logic [W-1:0] model_res(input logic dep,
                                               input logic [W-1:0] b,
                                               input logic [W-1:0] a);
        return dep ? b + a : b - a;
    endfunction

    // enter amount a on balance b, check the Enter outcome; returns viable
    task automatic run_enter(input logic dep, input logic [W-1:0] b,
                             input logic [W-1:0] a, input string req,
                             output logic viable);
        logic eb;
        bal_in = b;
        key_bits(a, W);
        press(4'hE);
        eb = model_bad(dep, b, a);
        if (!eb) exp_out = model_res(dep, b, a);
        chk(bad_txn == eb, {req, " invalid flag"}, bad_txn, eb);
        chk(bal_out == exp_out, {req, " new balance"}, bal_out, exp_out);
        chk(!txn_ok && !txn_cancel, {req, " no pulse at Enter"},
            {txn_ok, txn_cancel}, 0);
        viable = !eb;
    endtask

    task automatic finish_verify(input logic confirm, input string req);
        press(confirm ? 4'h1 : 4'h0);
        chk(txn_ok == confirm && txn_cancel == !confirm, {req, " pulse"},
            {txn_ok, txn_cancel}, {confirm, !confirm});
        @(negedge clk);
        chk(!txn_ok && !txn_cancel, {req, " pulse one cycle"},
            {txn_ok, txn_cancel}, 0);
    endtask

    initial begin
        #(CLK_PER * 40000);
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic v;
        void'($urandom(32'd2024));
        rst = 1'b1; dep_en = 0; wdr_en = 0; key_stb = 0; key_code = 0; bal_in = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(bal_out == 0 && !bad_txn && !txn_ok && !txn_cancel, "R1 reset",
            {bal_out, bad_txn, txn_ok, txn_cancel}, 0);

        // R2: keys with no enable are ignored, then amount 0 deposit
        press(4'h1); press(4'h1); press(4'hE);
        chk(bal_out == 0 && !bad_txn, "R2 Enter without enable", bal_out, 0);
        dep_en = 1; bal_in = 16'd100;
        press(4'hE);
        exp_out = 16'd100;
        chk(bal_out == 16'd100, "R2 disabled digits not kept", bal_out, 100);
        finish_verify(1'b0, "R11 cancel");

        // R3: first bit shifted out after W+1 digits; R10 amount cleared by Enter
        bal_in = 16'd50;
        press(4'h1); key_bits(16'h0003, W);
        press(4'hE);
        exp_out = 16'd53;
        chk(bal_out == 16'd53, "R3 R10 shift drops top bit", bal_out, 53);
        bal_in = 16'h1234;  // R12 held despite input change
        press(4'h5);
        chk(bal_out == 16'd53 && !txn_ok && !txn_cancel, "R12 ignored key",
            bal_out, 53);
        finish_verify(1'b1, "R11 confirm");

        // R4: clear mid entry
        bal_in = 16'd10;
        press(4'h1); press(4'h1); press(4'hC); press(4'h1);
        press(4'hE);
        exp_out = 16'd11;
        chk(bal_out == 16'd11, "R4 clear", bal_out, 11);
        finish_verify(1'b1, "R11 confirm");

        // R5 edges
        dep_en = 1; wdr_en = 0;
        run_enter(1'b1, 16'hFFFE, 16'd1, "R5 max sum", v);
        finish_verify(1'b1, "R11 confirm");
        run_enter(1'b1, 16'hFFFF, 16'd1, "R5 R9 overflow", v);
        // R9 flag persists through digit keys, no pulse
        press(4'h1);
        chk(bad_txn && bal_out == exp_out && !txn_ok, "R9 flag held",
            bad_txn, 1);
        press(4'hC);

        // R6 edges
        dep_en = 0; wdr_en = 1;
        run_enter(1'b0, 16'd777, 16'd777, "R6 equal gives zero", v);
        chk(bad_txn == 0, "R9 cleared by next Enter", bad_txn, 0);
        finish_verify(1'b0, "R11 cancel");
        run_enter(1'b0, 16'd777, 16'd778, "R6 R9 borrow", v);

        // R7: both enables -> deposit
        dep_en = 1; wdr_en = 1;
        run_enter(1'b1, 16'd300, 16'd20, "R7 both enables", v);
        finish_verify(1'b1, "R11 confirm");

        // random transactions
        for (int t = 0; t < 60; t++) begin
            logic [W-1:0] b, a;
            logic dep;
            int m;
            m = $urandom_range(0, 2);
            dep = (m != 1);
            dep_en = (m != 1);
            wdr_en = (m != 0);
            b = W'($urandom);
            a = W'($urandom);
            if (!dep && t % 4 == 0) a = b >> 1;
            run_enter(dep, b, a, dep ? "R5 R8 random" : "R6 R8 random", v);
            if (v) begin
                bal_in = W'($urandom);
                press(4'hE);
                chk(bal_out == exp_out && !txn_ok && !txn_cancel,
                    "R12 random hold", bal_out, exp_out);
                finish_verify(1'($urandom_range(0, 1)), "R11 random");
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule